// File: doc/BRIEF.md
# Trigger Source and Prescaler Unit

This unit produces the one-cycle start pulse that launches a delay sequencer. The pulse comes from one of two sources. The first is an internal period counter that runs on the main clock and fires once every N cycles. The second is an external trigger pin. The pin is brought into the clock domain by a synchroniser, and then edge-detected on a selectable slope. An optional gate input can qualify the edges, and a divide-by-K prescaler can thin them.

A tally counts every start pulse that actually leaves the unit. It raises a sticky flag once a programmed number of pulses has gone out, and that flag is meant to feed an interrupt line. A downstream busy signal blocks pulses while the sequencer cannot accept one. A blocked pulse is neither emitted nor counted.

The period N, prescale K and tally limit are held in registers. Each one is loaded by its own write strobe, and a write restarts the counter that uses the value. The other settings are level inputs.

Top module: `trig_source_unit`

## Requirements
- R1: After reset, `trig_o` and `hit_o` are low and N, K and the limit are all 0, so no pulse appears from either source.
- R2: With `src_ext_i`=0 and N≠0, `trig_o` pulses for one cycle every N cycles. The first pulse is visible in the Nth cycle after the cycle in which `period_wr_i` was sampled high, because a write restarts the period count.
- R3: With N=0 the internal source never fires.
- R4: `ext_trig_i` passes through a two-flop synchroniser. A qualifying change yields a pulse visible in the second cycle after the change, and the pulse lasts exactly one cycle.
- R5: `slope_fall_i`=0 accepts rising edges of `ext_trig_i`, and `slope_fall_i`=1 accepts falling edges.
- R6: With `gate_en_i`=1, an edge is accepted only if `gate_i`=1 in the cycle the edge is detected. With `gate_en_i`=0, `gate_i` has no effect.
- R7: The prescaler emits a pulse on every Kth accepted external edge, counting from a write of `presc_i`. With K=1 every accepted edge produces a pulse, and with K=0 the external source never fires.
- R8: `src_ext_i`=1 selects the external source and `src_ext_i`=0 selects the internal one. The source that is not selected never reaches `trig_o`.
- R9: While `busy_i`=1, `trig_o` stays low. A pulse suppressed this way is not counted by the tally.
- R10: With limit L≠0, `hit_o` rises in the cycle after the Lth counted pulse. It then holds, and counting stops, while pulses continue to be emitted. A write of the limit clears the count and the flag, and L=0 disables the flag.
- R11: `hit_clr_i` clears the count and `hit_o`. A pulse in the same cycle as the clear is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_ext_i | input | 1 | Source select: 1 external, 0 internal |
| slope_fall_i | input | 1 | External slope: 1 falling, 0 rising |
| gate_en_i | input | 1 | Enables gating of external edges |
| gate_i | input | 1 | Gate level for external edges |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| period_i | input | PERIOD_W | Internal period N |
| period_wr_i | input | 1 | Loads N and restarts the period count |
| presc_i | input | PRESC_W | Prescale factor K |
| presc_wr_i | input | 1 | Loads K and restarts the prescaler |
| limit_i | input | TALLY_W | Tally limit L |
| limit_wr_i | input | 1 | Loads L and clears the tally and flag |
| hit_clr_i | input | 1 | Clears the tally and flag |
| busy_i | input | 1 | Downstream busy; blocks pulses |
| trig_o | output | 1 | One-cycle start pulse |
| hit_o | output | 1 | Sticky count-reached flag |

## Verification
Two pairs of events can land in the same cycle. The first pair is a clear and a pulse that would be counted. The bench raises `hit_clr_i` in exactly the cycle an internal pulse is visible. It then judges the outcome by when `hit_o` returns: that must be after a full L further pulses, not after L−1. The second pair is busy and a due pulse. Busy is held over one scheduled internal pulse, and the bench checks that the flag arrives one pulse later than it would if the blocked pulse had been counted.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } trig_src_e;
endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  // sync stages plus one history flop for edge detection
  logic [STAGES:0] chain_q;

  for (genvar i = 0; i <= STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign rise_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/trig_modn.sv
module trig_modn #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cfg_i,
  input  logic         wr_i,
  input  logic         adv_i,
  output logic         fire_o
);
  logic [W-1:0] val_q, cnt_q;
  logic         active, last;

  assign active = (val_q != '0);
  assign last   = (cnt_q == val_q - 1'b1);
  assign fire_o = adv_i & active & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      cnt_q <= '0;
    end else if (wr_i) begin
      val_q <= cfg_i;
      cnt_q <= '0;
    end else if (adv_i && active) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/trig_tally.sv
module trig_tally #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] limit_i,
  input  logic         limit_wr_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic         hit_o
);
  logic [W-1:0] limit_q, cnt_q;
  logic         hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_q <= '0;
      cnt_q   <= '0;
      hit_q   <= 1'b0;
    end else if (limit_wr_i) begin
      limit_q <= limit_i;
      cnt_q   <= '0;
      hit_q   <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (inc_i && limit_q != '0 && !hit_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == limit_q - 1'b1) hit_q <= 1'b1;
    end
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/trig_source_unit.sv
module trig_source_unit
  import trig_pkg::*;
#(
  parameter int unsigned PERIOD_W    = 16,
  parameter int unsigned PRESC_W     = 8,
  parameter int unsigned TALLY_W     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                src_ext_i,
  input  logic                slope_fall_i,
  input  logic                gate_en_i,
  input  logic                gate_i,
  input  logic                ext_trig_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                period_wr_i,
  input  logic [PRESC_W-1:0]  presc_i,
  input  logic                presc_wr_i,
  input  logic [TALLY_W-1:0]  limit_i,
  input  logic                limit_wr_i,
  input  logic                hit_clr_i,
  input  logic                busy_i,
  output logic                trig_o,
  output logic                hit_o
);
  trig_src_e src;
  logic      int_fire, ext_fire, ext_rise, ext_fall, ext_qual, sel_fire;

  assign src = trig_src_e'(src_ext_i);

  trig_modn #(.W(PERIOD_W)) u_period (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (period_i),
    .wr_i   (period_wr_i),
    .adv_i  (1'b1),
    .fire_o (int_fire)
  );

  trig_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_trig_i),
    .rise_o  (ext_rise),
    .fall_o  (ext_fall)
  );

  assign ext_qual = (slope_fall_i ? ext_fall : ext_rise) & (~gate_en_i | gate_i);

  // prescaler counts qualified edges whatever the source select or busy
  trig_modn #(.W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (presc_i),
    .wr_i   (presc_wr_i),
    .adv_i  (ext_qual),
    .fire_o (ext_fire)
  );

  assign sel_fire = (src == SRC_EXT) ? ext_fire : int_fire;
  assign trig_o   = sel_fire & ~busy_i;

  trig_tally #(.W(TALLY_W)) u_tally (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .limit_i    (limit_i),
    .limit_wr_i (limit_wr_i),
    .clr_i      (hit_clr_i),
    .inc_i      (trig_o),
    .hit_o      (hit_o)
  );
endmodule

// File: rtl/trig_source_unit_chk.sv
module trig_source_unit_chk #(
  parameter int unsigned PERIOD_W = 16,
  parameter int unsigned PRESC_W  = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                src_ext_i,
  input logic                slope_fall_i,
  input logic [PERIOD_W-1:0] period_i,
  input logic                period_wr_i,
  input logic [PRESC_W-1:0]  presc_i,
  input logic                presc_wr_i,
  input logic                limit_wr_i,
  input logic                hit_clr_i,
  input logic                busy_i,
  input logic                trig_o,
  input logic                hit_o
);
  a_r9_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !trig_o);

  a_r10_hit_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && !hit_clr_i && !limit_wr_i |=> hit_o);

  a_r10_hit_after_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_o) |-> $past(trig_o));

  a_r10_limit_wr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limit_wr_i |=> !hit_o);

  a_r11_clr_drops_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_clr_i |=> !hit_o);

  a_r2_period_wr_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_wr_i && period_i != 1 && !src_ext_i |=> !(trig_o && !src_ext_i));

  a_r7_presc_wr_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    presc_wr_i && presc_i != 1 && src_ext_i |=> !(trig_o && src_ext_i));

  a_r4_ext_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ext_i && trig_o |=> !(trig_o && src_ext_i && $stable(slope_fall_i)));
endmodule

bind trig_source_unit trig_source_unit_chk #(
  .PERIOD_W (PERIOD_W),
  .PRESC_W  (PRESC_W)
) u_chk (
  .clk_i, .rst_ni, .src_ext_i, .slope_fall_i, .period_i, .period_wr_i,
  .presc_i, .presc_wr_i, .limit_wr_i, .hit_clr_i, .busy_i, .trig_o, .hit_o
);

// File: tb/trig_source_unit_bench.sv
`timescale 1ns/1ps
module trig_source_unit_bench;
  localparam int PW = 16, KW = 8, TW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic src_ext = 0, slope_fall = 0, gate_en = 0, gate = 0, ext = 0;
  logic [PW-1:0] period = '0;
  logic [KW-1:0] presc = '0;
  logic [TW-1:0] limit = '0;
  logic period_wr = 0, presc_wr = 0, limit_wr = 0, hit_clr = 0, busy = 0;
  logic trig, hit;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  trig_source_unit u_trig_source_unit (
    .clk_i(clk), .rst_ni(rst_n), .src_ext_i(src_ext), .slope_fall_i(slope_fall),
    .gate_en_i(gate_en), .gate_i(gate), .ext_trig_i(ext),
    .period_i(period), .period_wr_i(period_wr), .presc_i(presc), .presc_wr_i(presc_wr),
    .limit_i(limit), .limit_wr_i(limit_wr), .hit_clr_i(hit_clr), .busy_i(busy),
    .trig_o(trig), .hit_o(hit)
  );

  // bits: {slope_fall, gate_en, gate, new ext level, expected trig}
  localparam logic [4:0] VEC [0:7] = '{
    5'b0_0_0_1_1, 5'b0_0_0_0_0, 5'b1_0_0_1_0, 5'b1_0_0_0_1,
    5'b0_1_0_1_0, 5'b0_1_0_0_0, 5'b0_1_1_1_1, 5'b1_1_1_0_1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_period(input logic [PW-1:0] v);
    period = v; period_wr = 1; @(negedge clk); period_wr = 0;
  endtask
  task automatic wr_presc(input logic [KW-1:0] v);
    presc = v; presc_wr = 1; @(negedge clk); presc_wr = 0;
  endtask
  task automatic wr_limit(input logic [TW-1:0] v);
    limit = v; limit_wr = 1; @(negedge clk); limit_wr = 0;
  endtask
  // drive ext, then check the slot where a pulse would be visible
  task automatic ext_edge(input logic lvl, input logic exp, input string req);
    ext = lvl; @(negedge clk);
    chk("R4 pre", trig, 0);
    @(negedge clk);
    chk(req, trig, exp);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 trig in reset", trig, 0);
    chk("R1 hit in reset", hit, 0);
    rst_n = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R1 no trig after reset", trig, 0);
    end
    chk("R1 hit after reset", hit, 0);

    // external table walk, K=1
    src_ext = 1;
    wr_presc(1);
    for (int i = 0; i < 8; i++) begin
      slope_fall = VEC[i][4]; gate_en = VEC[i][3]; gate = VEC[i][2];
      ext_edge(VEC[i][1], VEC[i][0], "R5/R6 edge table");
    end

    // prescaler K=3 on rising edges
    slope_fall = 0; gate_en = 0;
    wr_presc(3);
    for (int e = 1; e <= 6; e++) begin
      ext_edge(1'b1, (e % 3) == 0, "R7 prescale K=3");
      ext_edge(1'b0, 1'b0, "R7 falling ignored");
    end
    wr_presc(0);
    ext_edge(1'b1, 1'b0, "R7 K=0 disables");
    ext_edge(1'b0, 1'b0, "R7 K=0 disables");

    // external selected: internal pulses must not reach output
    wr_presc(1);
    wr_period(2);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R8 internal masked", trig, 0);
    end
    // internal selected, N=0: no pulses, ext edge masked
    src_ext = 0;
    wr_period(0);
    ext_edge(1'b1, 1'b0, "R8 external masked");
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R3 N=0 silent", trig, 0);
    end
    ext = 0;

    // internal period N=4
    wr_period(4);
    for (int k = 1; k <= 12; k++) begin
      chk("R2 period N=4", trig, (k % 4) == 0);
      @(negedge clk);
    end

    // tally limit 3 with clear colliding with a pulse
    wr_period(0);
    wr_limit(3);
    wr_period(2);
    for (int k = 1; k <= 15; k++) begin
      if (k == 9) hit_clr = 0;
      chk("R10/R11 hit timing", hit, (k == 7 || k == 8 || k == 15));
      if (k == 8) begin
        chk("R10 pulses continue after hit", trig, 1);
        hit_clr = 1;
      end
      @(negedge clk);
    end

    // busy blocks a pulse and it is not counted
    wr_period(0);
    wr_limit(2);
    wr_period(2);
    for (int k = 1; k <= 7; k++) begin
      if (k == 2) chk("R9 busy suppresses", trig, 0);
      if (k == 5) chk("R9 blocked not counted", hit, 0);
      if (k == 7) chk("R9 hit after two real pulses", hit, 1);
      if (k == 1) busy = 1;
      if (k == 3) busy = 0;
      @(negedge clk);
    end
    wr_limit(0);
    repeat (8) @(negedge clk);
    chk("R10 L=0 disables flag", hit, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule